// File: doc/BRIEF.md
# Step/Direction Microstepping Indexer

This block converts a step pulse and a direction level into a position on one electrical cycle of a two-winding bipolar stepper. The cycle is divided into 128 positions, about 2.8 degrees apart. For each position the block gives each winding a signed current setpoint: a negative flag and a 5-bit magnitude code. A motor driver downstream turns these setpoints into chopping thresholds. Winding A follows a cosine shape and winding B follows a sine shape.

A 3-bit resolution input sets how far one step moves the position. The range runs from full step (32 positions per step, held on the four diagonal points) down to 1/32 step (one position per step). Only one quarter-wave of the shape is stored, at the finest resolution. Every other resolution walks that same storage with a larger stride. The step, direction, resolution and enable inputs may come from another clock domain, so each passes through a two-flop synchroniser. Direction and resolution are taken in the same cycle that the synchronised step edge is seen.

The block also gives an active-low flag while it sits at its home point. For each winding it gives a one-cycle pulse whenever a step lowers that winding's magnitude, which a downstream chopper can use to pick its decay behaviour.

Top module: `stepper_indexer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the position is 16 (45 degrees). Step edges seen during reset have no effect. After reset, both windings read magnitude 22 with negative flag 0, `home_n` is 0 and both falling pulses are 0.
- R2: With `dir_in` high, each rising edge of `step_in` moves the position forward by the stride of the resolution code. The codes are 000 = 32 positions, 001 = 16, 010 = 8, 011 = 4, 100 = 2, and 101, 110 and 111 = 1.
- R3: With `dir_in` low, each rising edge moves the position backward by the same stride.
- R4: In full-step mode (code 000) the position only visits 16, 48, 80 and 112, so both winding magnitudes read 22.
- R5: After a resolution change, the next step edge moves the position to the nearest valid position of the new resolution in the step direction. A position is valid when it is a multiple of the stride; in full-step mode it is valid when it is 16 more than a multiple of 32.
- R6: The position wraps modulo 128 in both directions.
- R7: Let position p be split as quadrant q = p[6:5] and offset k = p[4:0]. Winding B's magnitude is S(k) for q = 0 or 2, and S(32-k) for q = 1 or 3, where S(k) = round(31·sin(k·π/64)). Winding B's negative flag is p[6] when the magnitude is nonzero and 0 when it is zero. Winding A uses the same rule at position p+32 modulo 128.
- R8: `home_n` is 0 exactly when the position is 16, and 1 at every other position.
- R9: While the synchronised `enable_n` is high, step edges are ignored. The position, the setpoints and the falling pulses do not change.
- R10: On the cycle the position updates, a winding's falling output pulses high for one cycle if its new magnitude is lower than its old one. At all other times it is low.
- R11: A rising edge of `step_in` that arrives before clock edge E0 updates the position at edge E0+2. The position is unchanged after E0+1 and updated after E0+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Step pulse; acts on its rising edge |
| dir_in | input | 1 | Direction: 1 = forward, 0 = backward |
| mode_in | input | 3 | Step resolution code |
| enable_n | input | 1 | Active-low enable for stepping |
| home_n | output | 1 | Low while at the home position |
| pos_out | output | 7 | Current table position |
| a_neg | output | 1 | Winding A current is negative |
| a_mag | output | 5 | Winding A magnitude code |
| b_neg | output | 1 | Winding B current is negative |
| b_mag | output | 5 | Winding B magnitude code |
| a_falling | output | 1 | One-cycle pulse: winding A magnitude dropped |
| b_falling | output | 1 | One-cycle pulse: winding B magnitude dropped |

## Verification
A change of resolution and the step edge that acts on it can reach the sequencer in the same cycle. This is because the resolution code and the step pulse travel through the same synchroniser. The bench provokes this by driving a new code on the same clock as the step rising edge, starting from positions that are not valid in the new resolution (for example 19 going to quarter step, and 21 going to full step). The result is judged against an expected position found by searching forward or backward for the next valid index. Setpoints, the home flag and the falling pulses are checked at every step. The sign flip and the modulo wrap also coincide when a step crosses position 0 backward, and that case is checked explicitly.

// File: rtl/idx_pkg.sv
package idx_pkg;

    localparam int unsigned POS_W  = 7;
    localparam int unsigned QTR_W  = POS_W - 2;
    localparam int unsigned MAG_W  = 5;
    localparam int unsigned MODE_W = 3;
    localparam int unsigned FINEST = 5;

    localparam logic [POS_W-1:0] QUARTER_TURN = POS_W'(1 << QTR_W);
    localparam logic [POS_W-1:0] HOME_POS     = POS_W'(1 << (QTR_W - 1));

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } setpoint_t;

    function automatic logic [POS_W-1:0] stride_of(input logic [MODE_W-1:0] m);
        if (m >= MODE_W'(FINEST))
            return POS_W'(1);
        return POS_W'(1) << (MODE_W'(FINEST) - m);
    endfunction

    function automatic logic [POS_W-1:0] anchor_of(input logic [MODE_W-1:0] m);
        return (m == '0) ? HOME_POS : '0;
    endfunction

    function automatic logic [MAG_W-1:0] quarter_sine(input logic [QTR_W:0] k);
        case (k)
            6'd0:  return 5'd0;   6'd1:  return 5'd2;   6'd2:  return 5'd3;
            6'd3:  return 5'd5;   6'd4:  return 5'd6;   6'd5:  return 5'd8;
            6'd6:  return 5'd9;   6'd7:  return 5'd10;  6'd8:  return 5'd12;
            6'd9:  return 5'd13;  6'd10: return 5'd15;  6'd11: return 5'd16;
            6'd12: return 5'd17;  6'd13: return 5'd18;  6'd14: return 5'd20;
            6'd15: return 5'd21;  6'd16: return 5'd22;  6'd17: return 5'd23;
            6'd18: return 5'd24;  6'd19: return 5'd25;  6'd20: return 5'd26;
            6'd21: return 5'd27;  6'd22: return 5'd27;  6'd23: return 5'd28;
            6'd24: return 5'd29;  6'd25: return 5'd29;  6'd26: return 5'd30;
            6'd27: return 5'd30;  6'd28: return 5'd30;  default: return 5'd31;
        endcase
    endfunction

    function automatic setpoint_t winding_at(input logic [POS_W-1:0] p);
        logic [QTR_W:0] k;
        setpoint_t      r;
        if (p[QTR_W])
            k = (QTR_W+1)'(1 << QTR_W) - {1'b0, p[QTR_W-1:0]};
        else
            k = {1'b0, p[QTR_W-1:0]};
        r.mag = quarter_sine(k);
        r.neg = p[POS_W-1] & (r.mag != '0);
        return r;
    endfunction

endpackage

// File: rtl/idx_sync.sv
module idx_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/idx_sequencer.sv
module idx_sequencer
    import idx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_s,
    input  logic              dir_s,
    input  logic [MODE_W-1:0] mode_s,
    input  logic              enable_n_s,
    output logic [POS_W-1:0]  pos_q,
    output logic [POS_W-1:0]  pos_nxt,
    output logic              fire
);
    logic             step_d;
    logic [POS_W-1:0] stride;
    logic [POS_W-1:0] offset;

    assign fire   = step_s & ~step_d & ~enable_n_s;
    assign stride = stride_of(mode_s);
    assign offset = (pos_q - anchor_of(mode_s)) & (stride - POS_W'(1));

    always_comb begin
        if (dir_s)
            pos_nxt = pos_q + (stride - offset);
        else if (offset == '0)
            pos_nxt = pos_q - stride;
        else
            pos_nxt = pos_q - offset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_d <= 1'b0;
            pos_q  <= HOME_POS;
        end else begin
            step_d <= step_s;
            if (fire)
                pos_q <= pos_nxt;
        end
    end
endmodule

// File: rtl/idx_winding.sv
module idx_winding
    import idx_pkg::*;
#(
    parameter logic [POS_W-1:0] PHASE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos_q,
    input  logic [POS_W-1:0] pos_nxt,
    input  logic             fire,
    output setpoint_t        sp,
    output logic             falling
);
    setpoint_t sp_nxt;

    assign sp     = winding_at(pos_q + PHASE);
    assign sp_nxt = winding_at(pos_nxt + PHASE);

    always_ff @(posedge clk) begin
        if (rst)
            falling <= 1'b0;
        else
            falling <= fire && (sp_nxt.mag < sp.mag);
    end
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
    import idx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_in,
    input  logic              dir_in,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              enable_n,
    output logic              home_n,
    output logic [POS_W-1:0]  pos_out,
    output logic              a_neg,
    output logic [MAG_W-1:0]  a_mag,
    output logic              b_neg,
    output logic [MAG_W-1:0]  b_mag,
    output logic              a_falling,
    output logic              b_falling
);
    localparam int unsigned SYNC_W = MODE_W + 3;
    localparam int unsigned NWIND  = 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << (SYNC_W - 1);
    localparam logic [POS_W-1:0] PHASES [NWIND] = '{QUARTER_TURN, '0};

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic              step_s, dir_s, enable_n_s;
    logic [MODE_W-1:0] mode_s;
    logic [POS_W-1:0]  pos_q, pos_nxt;
    logic              fire;
    setpoint_t         sp   [NWIND];
    logic              fall [NWIND];

    assign raw_in = {enable_n, mode_in, dir_in, step_in};
    assign {enable_n_s, mode_s, dir_s, step_s} = sync_out;

    idx_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
    );

    idx_sequencer u_seq (
        .clk(clk), .rst(rst), .step_s(step_s), .dir_s(dir_s),
        .mode_s(mode_s), .enable_n_s(enable_n_s),
        .pos_q(pos_q), .pos_nxt(pos_nxt), .fire(fire)
    );

    for (genvar w = 0; w < NWIND; w++) begin : g_wind
        idx_winding #(.PHASE(PHASES[w])) u_wind (
            .clk(clk), .rst(rst), .pos_q(pos_q), .pos_nxt(pos_nxt),
            .fire(fire), .sp(sp[w]), .falling(fall[w])
        );
    end

    assign pos_out   = pos_q;
    assign home_n    = (pos_q != HOME_POS);
    assign a_neg     = sp[0].neg;
    assign a_mag     = sp[0].mag;
    assign b_neg     = sp[1].neg;
    assign b_mag     = sp[1].mag;
    assign a_falling = fall[0];
    assign b_falling = fall[1];
endmodule

// File: rtl/idx_checker.sv
module idx_checker (
    input logic       clk,
    input logic       rst,
    input logic       home_n,
    input logic [6:0] pos_out,
    input logic       a_neg,
    input logic [4:0] a_mag,
    input logic       b_neg,
    input logic [4:0] b_mag,
    input logic       a_falling,
    input logic       b_falling
);
    AST_RESET_HOME: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pos_out == 7'd16)); // R1

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (7'(pos_out - $past(pos_out)) <= 7'd32) ||
        (7'(pos_out - $past(pos_out)) >= 7'd96)); // R2

    AST_ZERO_A_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
        (a_mag == 5'd0) |-> !a_neg); // R7

    AST_ZERO_B_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
        (b_mag == 5'd0) |-> !b_neg); // R7

    AST_HOME_BALANCED: assert property (@(posedge clk) disable iff (rst)
        !home_n |-> (a_mag == b_mag && !a_neg && !b_neg)); // R8

    AST_FALL_A_SINGLE: assert property (@(posedge clk) disable iff (rst)
        a_falling |=> !a_falling); // R10

    AST_FALL_B_SINGLE: assert property (@(posedge clk) disable iff (rst)
        b_falling |=> !b_falling); // R10

    AST_FALL_NEEDS_MOVE: assert property (@(posedge clk) disable iff (rst)
        (a_falling || b_falling) |-> (pos_out != $past(pos_out))); // R10
endmodule

bind stepper_indexer idx_checker u_chk (
    .clk(clk), .rst(rst), .home_n(home_n), .pos_out(pos_out),
    .a_neg(a_neg), .a_mag(a_mag), .b_neg(b_neg), .b_mag(b_mag),
    .a_falling(a_falling), .b_falling(b_falling)
);

// File: tb/tb_stepper_indexer.sv
module tb_stepper_indexer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_in = 1'b0;
    logic       dir_in = 1'b0;
    logic [2:0] mode_in = 3'd0;
    logic       enable_n = 1'b0;
    logic       home_n, a_neg, b_neg, a_falling, b_falling;
    logic [6:0] pos_out;
    logic [4:0] a_mag, b_mag;

    int n_chk = 0;
    int n_bad = 0;
    int pos_m = 16;
    bit done = 1'b0;

    always #4ns clk = ~clk;

    stepper_indexer dut (
        .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
        .mode_in(mode_in), .enable_n(enable_n), .home_n(home_n),
        .pos_out(pos_out), .a_neg(a_neg), .a_mag(a_mag), .b_neg(b_neg),
        .b_mag(b_mag), .a_falling(a_falling), .b_falling(b_falling)
    );

    // {mode[2:0], dir, count[7:0]}
    localparam logic [11:0] VEC [8] = '{
        {3'd0, 1'b1, 8'd5},  {3'd0, 1'b0, 8'd2},
        {3'd1, 1'b1, 8'd9},  {3'd2, 1'b0, 8'd11},
        {3'd3, 1'b1, 8'd20}, {3'd4, 1'b0, 8'd40},
        {3'd5, 1'b1, 8'd70}, {3'd7, 1'b0, 8'd30}
    };

    function automatic int qs(int k);
        return int'($floor(31.0 * $sin(k * 3.14159265358979 / 64.0) + 0.5));
    endfunction

    function automatic int mag_of(int p);
        int q = (p >> 5) & 3;
        int k = p & 31;
        return (q % 2 == 1) ? qs(32 - k) : qs(k);
    endfunction

    function automatic int neg_of(int p);
        return (((p >> 6) & 1) == 1 && mag_of(p) != 0) ? 1 : 0;
    endfunction

    function automatic bit valid_at(int p, int m);
        int s = (m >= 5) ? 1 : (32 >> m);
        if (m == 0) return (p % 32) == 16;
        return (p % s) == 0;
    endfunction

    function automatic int next_pos(int p, int m, int d);
        int r = p;
        do r = d ? ((r + 1) & 127) : ((r + 127) & 127);
        while (!valid_at(r, m));
        return r;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req, input int m);
        int pa = (pos_m + 32) & 127;
        chk(req, "position", int'(pos_out), pos_m);
        chk("R7", "a_mag", int'(a_mag), mag_of(pa));
        chk("R7", "a_neg", int'(a_neg), neg_of(pa));
        chk("R7", "b_mag", int'(b_mag), mag_of(pos_m));
        chk("R7", "b_neg", int'(b_neg), neg_of(pos_m));
        chk("R8", "home_n", int'(home_n), (pos_m == 16) ? 0 : 1);
        if (m == 0) begin
            chk("R4", "full a_mag", int'(a_mag), 22);
            chk("R4", "full b_mag", int'(b_mag), 22);
        end
    endtask

    task automatic do_step(input int m, input int d, input bit moves, input string req);
        int old_a = mag_of((pos_m + 32) & 127);
        int old_b = mag_of(pos_m);
        int fa = 0;
        int fb = 0;
        @(negedge clk);
        mode_in = 3'(m);
        dir_in  = d[0];
        step_in = 1'b1;
        repeat (6) begin
            @(negedge clk);
            fa += int'(a_falling);
            fb += int'(b_falling);
        end
        step_in = 1'b0;
        repeat (3) @(negedge clk);
        if (moves) pos_m = next_pos(pos_m, m, d);
        check_outputs(req, m);
        chk("R10", "a_falling pulses", fa, (mag_of((pos_m + 32) & 127) < old_a) ? 1 : 0);
        chk("R10", "b_falling pulses", fb, (mag_of(pos_m) < old_b) ? 1 : 0);
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        pos_m = 16;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check_outputs("R1", 0);
        chk("R1", "a_mag", int'(a_mag), 22);
        chk("R1", "b_mag", int'(b_mag), 22);
        chk("R1", "home_n", int'(home_n), 0);
        chk("R1", "falling", int'(a_falling) + int'(b_falling), 0);

        // table walk: R2 forward, R3 backward
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < int'(VEC[v][7:0]); i++)
                do_step(int'(VEC[v][11:9]), int'(VEC[v][8]), 1'b1, VEC[v][8] ? "R2" : "R3");
        end

        // R5: resolution change together with the step edge
        reset_dut();
        repeat (3) do_step(5, 1, 1'b1, "R2");
        do_step(2, 1, 1'b1, "R5");
        chk("R5", "19 to quarter fwd", int'(pos_out), 24);
        repeat (3) do_step(6, 0, 1'b1, "R3");
        do_step(0, 0, 1'b1, "R5");
        chk("R5", "21 to full back", int'(pos_out), 16);
        do_step(5, 1, 1'b1, "R2");
        do_step(0, 1, 1'b1, "R5");
        chk("R5", "17 to full fwd", int'(pos_out), 48);

        // R6: wrap in both directions
        reset_dut();
        repeat (17) do_step(5, 0, 1'b1, "R3");
        chk("R6", "wrap backward", int'(pos_out), 127);
        do_step(5, 1, 1'b1, "R6");
        chk("R6", "wrap forward", int'(pos_out), 0);
        do_step(0, 0, 1'b1, "R6");
        chk("R6", "full wrap backward", int'(pos_out), 112);

        // R9: steps ignored while disabled
        @(negedge clk);
        enable_n = 1'b1;
        repeat (4) @(negedge clk);
        do_step(5, 1, 1'b0, "R9");
        do_step(1, 0, 1'b0, "R9");
        chk("R9", "position held", int'(pos_out), 112);
        @(negedge clk);
        enable_n = 1'b0;
        repeat (4) @(negedge clk);
        do_step(5, 1, 1'b1, "R9");
        chk("R9", "moves when enabled", int'(pos_out), 113);

        // R11: latency from step input to position
        @(negedge clk);
        mode_in = 3'd5;
        dir_in  = 1'b1;
        step_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "not yet moved", int'(pos_out), pos_m);
        @(negedge clk);
        chk("R11", "moved", int'(pos_out), pos_m + 1);
        step_in = 1'b0;
        repeat (3) @(negedge clk);
        pos_m = pos_m + 1;

        // R1: reset mid-run with a step pulse during reset
        @(negedge clk);
        rst = 1'b1;
        step_in = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        pos_m = 16;
        chk("R1", "position after reset", int'(pos_out), 16);
        chk("R1", "home_n after reset", int'(home_n), 0);
        check_outputs("R1", 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule